// File: doc/BRIEF.md
# SDRAM Write Burst Sequencer

This block turns a ready/valid host request stream into SDRAM command, address, bank and write-data pin activity for a two-bank device. The host asks for one of four operations (write, read, precharge, activate). A write either opens a new burst, and the block then issues a WRITE command, or, while a burst it opened is still running, supplies the next data beat on a NOP cycle. A last flag closes the host side of a burst. Any device burst cycles that remain after that are masked with DQM.

A write burst can be cut short by a READ or by a PRECHARGE to the burst's bank, unless that burst was opened with auto precharge. Each bank has two small counters. One holds PRECHARGE back until write recovery has elapsed since the bank's last unmasked data cycle. The other holds every command to the bank back until the precharge period has passed. Both periods are turned into clock counts at elaboration. The block holds a request by dropping ready and drives NOP in that cycle. The burst length may be fixed, or full-page through a parameter.

Top module: `sdr_wr_burst_seq`

## Requirements
- R1: A write request that does not continue an open burst is issued as a WRITE command in the cycle after acceptance, with its bank, column and first data beat and DQM low. Writes accepted back to back go out on consecutive cycles to any bank or column. The command pins {ras_n,cas_n,we_n} encode ACTIVE=011, READ=101, WRITE=100, PRECHARGE=010 and NOP=111.
- R2: A READ ends the running write burst. On the READ cycle the data bus is released (dq_oe low), and the next write request becomes a new WRITE command rather than a data beat.
- R3: A WRITE requested with auto precharge drives address bit 10 high. Until its burst's final cycle has gone out, every request except its own data beats is held with ready low.
- R4: A PRECHARGE to a bank goes out no earlier than TWR cycles after that bank's last unmasked write data cycle. With the default 10 ns clock and 15 ns recovery, TWR is 2.
- R5: TWR is ceil(tWR/tCK) but never less than 2. With a 4 ns recovery time, a PRECHARGE follows its bank's last data cycle by exactly 2 cycles when requested at once.
- R6: DQM is high on every write burst cycle that carries no host data, including the cycle where a PRECHARGE truncates the burst. DQM is low on data cycles, so a burst whose beats are all supplied is never masked.
- R7: No command reaches a bank within TRP cycles of its PRECHARGE (ceil(tRP/tCK), 3 by default).
- R8: A fixed burst completed and then precharged at the earliest legal time lets the bank's next ACTIVE go out in the same cycle relative to its WRITE as the same burst with auto precharge (WRITE+8 by default).
- R9: In full-page mode the burst runs with DQM high after the host's last beat until a READ, a WRITE or a PRECHARGE to its bank. The auto precharge request is ignored, so address bit 10 stays low.
- R10: Out of reset the pins show NOP with dq_oe and DQM low and ready high. Any cycle without an accepted request is followed by a NOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Host request valid |
| req_ready_o | output | 1 | Request accepted this cycle when valid |
| req_op_i | input | 2 | 0 write, 1 read, 2 precharge, 3 activate |
| req_bank_i | input | BANK_W | Target bank |
| req_addr_i | input | ADDR_W | Row for activate, column in low bits otherwise |
| req_data_i | input | DATA_W | Write data beat |
| req_last_i | input | 1 | Final host beat of a write burst |
| req_ap_i | input | 1 | Auto precharge for a write |
| sd_ras_n_o | output | 1 | Row strobe |
| sd_cas_n_o | output | 1 | Column strobe |
| sd_we_n_o | output | 1 | Write enable |
| sd_ba_o | output | BANK_W | Bank address |
| sd_addr_o | output | ADDR_W | Row/column address, bit 10 auto precharge |
| sd_dq_o | output | DATA_W | Write data |
| sd_dq_oe_o | output | 1 | Data bus drive enable |
| sd_dqm_o | output | 1 | Data mask |

## Verification
Assertions check on every cycle that the bus is released on a READ, that no PRECHARGE follows a data cycle of its own bank directly, and that idle cycles give NOP. They also check that no command passes a bank's recovery or precharge counter and that nothing cuts into a burst with auto precharge. Only the bench's scenarios show the exact issue cycles: the 2-cycle and 3-cycle spacings, the matching ACTIVE cycle of the auto precharge and manual precharge routes, and the masking of unsupplied beats in fixed and full-page bursts.

// File: rtl/sdr_seq_pkg.sv
package sdr_seq_pkg;
  typedef enum logic [1:0] {OP_WR = 2'd0, OP_RD = 2'd1, OP_PRE = 2'd2, OP_ACT = 2'd3} host_op_e;
  // {ras_n, cas_n, we_n}
  typedef enum logic [2:0] {
    CMD_ACT = 3'b011, CMD_RD = 3'b101, CMD_WR = 3'b100,
    CMD_PRE = 3'b010, CMD_NOP = 3'b111
  } sd_cmd_e;

  function automatic int ps_to_cyc(int t_ps, int tck_ps);
    return (t_ps + tck_ps - 1) / tck_ps;
  endfunction
endpackage

// File: rtl/sdr_bank_timer.sv
module sdr_bank_timer #(
  parameter int TWR_CYC = 2,
  parameter int TRP_CYC = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic data_i,
  input  logic pre_i,
  input  logic ap_end_i,
  input  logic issue_i,
  output logic wr_ok_o,
  output logic rp_ok_o
);
  localparam int CNT_W = $clog2(TWR_CYC + TRP_CYC + 1);
  localparam logic [CNT_W-1:0] WR_LOAD = CNT_W'(TWR_CYC);
  localparam logic [CNT_W-1:0] RP_LOAD = CNT_W'(TRP_CYC);
  localparam logic [CNT_W-1:0] AP_LOAD = CNT_W'(TWR_CYC + TRP_CYC);

  logic [CNT_W-1:0] wr_q, rp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q <= '0;
      rp_q <= '0;
    end else begin
      if (data_i)         wr_q <= WR_LOAD;
      else if (wr_q != 0) wr_q <= wr_q - 1'b1;
      if (pre_i)          rp_q <= RP_LOAD;
      else if (ap_end_i)  rp_q <= AP_LOAD;
      else if (rp_q != 0) rp_q <= rp_q - 1'b1;
    end
  end

  // counter value 1 means the period ends with the next pin cycle
  assign wr_ok_o = (wr_q <= CNT_W'(1));
  assign rp_ok_o = (rp_q <= CNT_W'(1));

  AST_WR_RECOVERY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pre_i |-> wr_ok_o); // R4
  AST_RP_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_i |-> rp_ok_o); // R7
endmodule

// File: rtl/sdr_burst_track.sv
module sdr_burst_track #(
  parameter int BURST_LEN = 4,
  parameter bit FULL_PAGE = 1'b0,
  parameter int BANK_W    = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_cmd_i,
  input  logic              wr_last_i,
  input  logic              wr_ap_i,
  input  logic [BANK_W-1:0] wr_bank_i,
  input  logic              beat_i,
  input  logic              beat_last_i,
  input  logic              stop_i,
  output logic              cont_o,
  output logic              open_o,
  output logic              ap_o,
  output logic [BANK_W-1:0] bank_o,
  output logic              nxt_burst_o,
  output logic              ap_end_o,
  output logic [BANK_W-1:0] ap_end_bank_o
);
  localparam int REM_W = (BURST_LEN > 1) ? $clog2(BURST_LEN + 1) : 1;
  localparam logic [REM_W-1:0] REM_INIT = REM_W'(BURST_LEN - 1);
  localparam bit SINGLE = (BURST_LEN == 1);

  logic [REM_W-1:0]  rem_q, rem_d;
  logic              run_q, run_d, open_q, open_d, ap_q, ap_d, nxt_final;
  logic [BANK_W-1:0] bank_q, bank_d;

  assign cont_o = FULL_PAGE ? run_q : (rem_q != '0);

  always_comb begin
    rem_d = rem_q; run_d = run_q; open_d = open_q; ap_d = ap_q; bank_d = bank_q;
    nxt_burst_o = 1'b0;
    nxt_final   = 1'b0;
    if (wr_cmd_i) begin
      rem_d       = REM_INIT;
      run_d       = 1'b1;
      open_d      = !wr_last_i;
      ap_d        = wr_ap_i && !FULL_PAGE;
      bank_d      = wr_bank_i;
      nxt_burst_o = 1'b1;
      nxt_final   = !FULL_PAGE && SINGLE;
    end else if (stop_i) begin
      rem_d  = '0;
      run_d  = 1'b0;
      open_d = 1'b0;
      ap_d   = 1'b0;
    end else if (cont_o) begin
      if (!FULL_PAGE) rem_d = rem_q - 1'b1;
      nxt_burst_o = 1'b1;
      nxt_final   = !FULL_PAGE && (rem_q == REM_W'(1));
      open_d      = open_q && !(beat_i && beat_last_i) && (FULL_PAGE || rem_q > REM_W'(1));
    end
  end

  assign ap_end_o      = nxt_final && ap_d;
  assign ap_end_bank_o = bank_d;
  assign open_o        = open_q;
  assign ap_o          = ap_q;
  assign bank_o        = bank_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q <= '0; run_q <= 1'b0; open_q <= 1'b0; ap_q <= 1'b0; bank_q <= '0;
    end else begin
      rem_q <= rem_d; run_q <= run_d; open_q <= open_d; ap_q <= ap_d; bank_q <= bank_d;
    end
  end

  AST_AP_NO_TRUNC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ap_q && cont_o) |-> !(stop_i || wr_cmd_i)); // R3
endmodule

// File: rtl/sdr_wr_burst_seq.sv
module sdr_wr_burst_seq
  import sdr_seq_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  parameter int ADDR_W    = 12,
  parameter int COL_W     = 9,
  parameter int DATA_W    = 8,
  parameter int BURST_LEN = 4,
  parameter bit FULL_PAGE = 1'b0,
  parameter int TCK_PS    = 10000,
  parameter int TWR_PS    = 15000,
  parameter int TRP_PS    = 30000,
  localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [1:0]        req_op_i,
  input  logic [BANK_W-1:0] req_bank_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_data_i,
  input  logic              req_last_i,
  input  logic              req_ap_i,
  output logic              sd_ras_n_o,
  output logic              sd_cas_n_o,
  output logic              sd_we_n_o,
  output logic [BANK_W-1:0] sd_ba_o,
  output logic [ADDR_W-1:0] sd_addr_o,
  output logic [DATA_W-1:0] sd_dq_o,
  output logic              sd_dq_oe_o,
  output logic              sd_dqm_o
);
  localparam int AP_BIT  = 10;
  localparam int TWR_RAW = ps_to_cyc(TWR_PS, TCK_PS);
  localparam int TWR_CYC = (TWR_RAW < 2) ? 2 : TWR_RAW;
  localparam int TRP_RAW = ps_to_cyc(TRP_PS, TCK_PS);
  localparam int TRP_CYC = (TRP_RAW < 1) ? 1 : TRP_RAW;

  host_op_e          op;
  logic              cont, open, ap_live, nxt_burst, ap_end;
  logic [BANK_W-1:0] burst_bank, ap_end_bank, dbank;
  logic              is_beat, cmd_ok, fire, wr_cmd, pre_stop, rd_stop, data_nxt;
  logic [NUM_BANKS-1:0] wr_ok, rp_ok;

  sd_cmd_e           cmd_q, cmd_n;
  logic [BANK_W-1:0] ba_q, ba_n;
  logic [ADDR_W-1:0] addr_q, addr_n;
  logic [DATA_W-1:0] dq_q;
  logic              oe_q, dqm_q, dqm_n, ldat_q;
  logic [BANK_W-1:0] ldat_bank_q;

  assign op      = host_op_e'(req_op_i);
  assign is_beat = req_valid_i && op == OP_WR && open && cont;
  assign cmd_ok  = !(ap_live && cont) && rp_ok[req_bank_i] && (op != OP_PRE || wr_ok[req_bank_i]);
  assign req_ready_o = is_beat || cmd_ok;
  assign fire     = req_valid_i && !is_beat && cmd_ok;
  assign wr_cmd   = fire && op == OP_WR;
  assign rd_stop  = fire && op == OP_RD;
  assign pre_stop = fire && op == OP_PRE && req_bank_i == burst_bank;
  assign data_nxt = wr_cmd || is_beat;
  assign dbank    = wr_cmd ? req_bank_i : burst_bank;

  sdr_burst_track #(
    .BURST_LEN(BURST_LEN), .FULL_PAGE(FULL_PAGE), .BANK_W(BANK_W)
  ) u_track (
    .clk_i, .rst_ni,
    .wr_cmd_i(wr_cmd), .wr_last_i(req_last_i), .wr_ap_i(req_ap_i), .wr_bank_i(req_bank_i),
    .beat_i(is_beat), .beat_last_i(req_last_i), .stop_i(rd_stop || pre_stop),
    .cont_o(cont), .open_o(open), .ap_o(ap_live), .bank_o(burst_bank),
    .nxt_burst_o(nxt_burst), .ap_end_o(ap_end), .ap_end_bank_o(ap_end_bank)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic hit;
    assign hit = req_bank_i == BANK_W'(b);
    sdr_bank_timer #(.TWR_CYC(TWR_CYC), .TRP_CYC(TRP_CYC)) u_timer (
      .clk_i, .rst_ni,
      .data_i  (data_nxt && dbank == BANK_W'(b)),
      .pre_i   (fire && op == OP_PRE && hit),
      .ap_end_i(ap_end && ap_end_bank == BANK_W'(b)),
      .issue_i (fire && hit),
      .wr_ok_o (wr_ok[b]),
      .rp_ok_o (rp_ok[b])
    );
  end

  always_comb begin
    cmd_n  = CMD_NOP;
    ba_n   = ba_q;
    addr_n = addr_q;
    if (fire) begin
      ba_n = req_bank_i;
      unique case (op)
        OP_WR: begin
          cmd_n          = CMD_WR;
          addr_n         = ADDR_W'(req_addr_i[COL_W-1:0]);
          addr_n[AP_BIT] = req_ap_i && !FULL_PAGE;
        end
        OP_RD: begin
          cmd_n  = CMD_RD;
          addr_n = ADDR_W'(req_addr_i[COL_W-1:0]);
        end
        OP_PRE: begin
          cmd_n  = CMD_PRE;
          addr_n = '0;
        end
        default: begin
          cmd_n  = CMD_ACT;
          addr_n = req_addr_i;
        end
      endcase
    end
    // mask burst cycles without host data, and the truncating precharge edge
    dqm_n = (nxt_burst && !data_nxt) || (pre_stop && cont);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q <= CMD_NOP; ba_q <= '0; addr_q <= '0; dq_q <= '0;
      oe_q <= 1'b0; dqm_q <= 1'b0; ldat_q <= 1'b0; ldat_bank_q <= '0;
    end else begin
      cmd_q  <= cmd_n;
      ba_q   <= ba_n;
      addr_q <= addr_n;
      if (data_nxt) dq_q <= req_data_i;
      oe_q   <= nxt_burst;
      dqm_q  <= dqm_n;
      ldat_q <= data_nxt;
      ldat_bank_q <= dbank;
    end
  end

  assign {sd_ras_n_o, sd_cas_n_o, sd_we_n_o} = cmd_q;
  assign sd_ba_o    = ba_q;
  assign sd_addr_o  = addr_q;
  assign sd_dq_o    = dq_q;
  assign sd_dq_oe_o = oe_q;
  assign sd_dqm_o   = dqm_q;

  AST_READ_RELEASES_BUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_q == CMD_RD) |-> !oe_q); // R2
  AST_TWR_MIN_TWO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_q == CMD_PRE) |-> !($past(ldat_q) && $past(ldat_bank_q) == ba_q)); // R5
  AST_IDLE_NOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_valid_i && req_ready_o) |=> (cmd_q == CMD_NOP)); // R10
endmodule

// File: tb/sim_sdr_wr_burst_seq.sv
module sim_sdr_wr_burst_seq;
  localparam logic [2:0] C_NOP = 3'b111, C_ACT = 3'b011, C_RD = 3'b101,
                         C_WR = 3'b100, C_PRE = 3'b010;
  localparam logic [1:0] O_WR = 2'd0, O_RD = 2'd1, O_PRE = 2'd2, O_ACT = 2'd3;

  logic clk = 1'b0, rst_ni = 1'b0;
  always #5 clk = ~clk;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;
  int n_chk = 0, n_bad = 0;

  logic       v0 = 0, l0 = 0, ap0 = 0, bk0 = 0, rdy0;
  logic [1:0] op0 = 0;
  logic [11:0] a0 = 0;
  logic [7:0] d0 = 0;
  logic ras0, cas0, we0, ba0, oe0, dqm0;
  logic [11:0] ad0;
  logic [7:0] dq0;

  logic       v1 = 0, l1 = 0, ap1 = 0, bk1 = 0, rdy1;
  logic [1:0] op1 = 0;
  logic [11:0] a1 = 0;
  logic [7:0] d1 = 0;
  logic ras1, cas1, we1, ba1, oe1, dqm1;
  logic [11:0] ad1;
  logic [7:0] dq1;

  sdr_wr_burst_seq u0 (
    .clk_i(clk), .rst_ni, .req_valid_i(v0), .req_ready_o(rdy0), .req_op_i(op0),
    .req_bank_i(bk0), .req_addr_i(a0), .req_data_i(d0), .req_last_i(l0), .req_ap_i(ap0),
    .sd_ras_n_o(ras0), .sd_cas_n_o(cas0), .sd_we_n_o(we0), .sd_ba_o(ba0), .sd_addr_o(ad0),
    .sd_dq_o(dq0), .sd_dq_oe_o(oe0), .sd_dqm_o(dqm0));

  sdr_wr_burst_seq #(.FULL_PAGE(1'b1), .TWR_PS(4000), .TRP_PS(10000)) u1 (
    .clk_i(clk), .rst_ni, .req_valid_i(v1), .req_ready_o(rdy1), .req_op_i(op1),
    .req_bank_i(bk1), .req_addr_i(a1), .req_data_i(d1), .req_last_i(l1), .req_ap_i(ap1),
    .sd_ras_n_o(ras1), .sd_cas_n_o(cas1), .sd_we_n_o(we1), .sd_ba_o(ba1), .sd_addr_o(ad1),
    .sd_dq_o(dq1), .sd_dq_oe_o(oe1), .sd_dqm_o(dqm1));

  task automatic chk(string rq, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  // called at a negedge; returns at the negedge where the command shows on the pins
  task automatic send0(input logic [1:0] op, input logic bk, input logic [11:0] a,
                       input logic [7:0] d, input logic lst, input logic ap, output int c);
    op0 = op; bk0 = bk; a0 = a; d0 = d; l0 = lst; ap0 = ap; v0 = 1'b1;
    #1;
    while (!rdy0) begin @(negedge clk); #1; end
    @(posedge clk); @(negedge clk);
    v0 = 1'b0; c = cyc;
  endtask

  task automatic send1(input logic [1:0] op, input logic bk, input logic [11:0] a,
                       input logic [7:0] d, input logic lst, input logic ap, output int c);
    op1 = op; bk1 = bk; a1 = a; d1 = d; l1 = lst; ap1 = ap; v1 = 1'b1;
    #1;
    while (!rdy1) begin @(negedge clk); #1; end
    @(posedge clk); @(negedge clk);
    v1 = 1'b0; c = cyc;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R10", "cmd", {ras0, cas0, we0}, C_NOP);
    chk("R10", "dqm", dqm0, 0);
    chk("R10", "oe", oe0, 0);
    chk("R10", "ready", rdy0, 1);
  endtask

  task automatic t_random();
    int c, prev = 0;
    for (int i = 0; i < 4; i++) begin
      send0(O_WR, i[0], 12'(i * 5 + 3), 8'(8'h10 + i), 1'b1, 1'b0, c);
      chk("R1", "cmd", {ras0, cas0, we0}, C_WR);
      chk("R1", "bank", ba0, i % 2);
      chk("R1", "col", ad0, i * 5 + 3);
      chk("R1", "dq", dq0, 8'h10 + i);
      chk("R1", "dqm", dqm0, 0);
      if (i > 0) chk("R1", "spacing", c - prev, 1);
      prev = c;
    end
    idle(1);
    chk("R6", "masked beat dqm", dqm0, 1);
    chk("R6", "masked beat oe", oe0, 1);
    chk("R6", "masked beat cmd", {ras0, cas0, we0}, C_NOP);
  endtask

  task automatic t_read_trunc();
    int w, c;
    idle(6);
    send0(O_WR, 1'b0, 12'd8, 8'hA0, 1'b0, 1'b0, w);
    send0(O_WR, 1'b0, 12'd0, 8'hA1, 1'b0, 1'b0, c);
    chk("R2", "beat cmd", {ras0, cas0, we0}, C_NOP);
    chk("R2", "beat dq", dq0, 8'hA1);
    chk("R2", "beat dqm", dqm0, 0);
    send0(O_RD, 1'b1, 12'd4, 8'h00, 1'b0, 1'b0, c);
    chk("R2", "read cmd", {ras0, cas0, we0}, C_RD);
    chk("R2", "read cycle", c - w, 2);
    chk("R2", "read oe", oe0, 0);
    send0(O_WR, 1'b0, 12'd20, 8'hA2, 1'b1, 1'b0, c);
    chk("R2", "new write cmd", {ras0, cas0, we0}, C_WR);
    chk("R2", "new write col", ad0, 20);
  endtask

  task automatic t_pre_trunc();
    int w, d, p, a;
    idle(6);
    send0(O_WR, 1'b0, 12'd0, 8'hB0, 1'b0, 1'b0, w);
    send0(O_WR, 1'b0, 12'd0, 8'hB1, 1'b1, 1'b0, d);
    chk("R6", "last beat dqm", dqm0, 0);
    send0(O_PRE, 1'b0, 12'd0, 8'h00, 1'b0, 1'b0, p);
    chk("R4", "pre cmd", {ras0, cas0, we0}, C_PRE);
    chk("R4", "pre after last data", p - d, 2);
    chk("R6", "pre edge dqm", dqm0, 1);
    send0(O_ACT, 1'b0, 12'h155, 8'h00, 1'b0, 1'b0, a);
    chk("R7", "act after pre", a - p, 3);
    chk("R7", "act row", ad0, 12'h155);
  endtask

  task automatic t_ap_equiv();
    int w1, a1c, w2, a2c, c;
    idle(8);
    send0(O_WR, 1'b0, 12'd16, 8'hC0, 1'b0, 1'b0, w1);
    send0(O_WR, 1'b0, 12'd0, 8'hC1, 1'b0, 1'b0, c);
    send0(O_WR, 1'b0, 12'd0, 8'hC2, 1'b0, 1'b0, c);
    send0(O_WR, 1'b0, 12'd0, 8'hC3, 1'b1, 1'b0, c);
    send0(O_PRE, 1'b0, 12'd0, 8'h00, 1'b0, 1'b0, c);
    send0(O_ACT, 1'b0, 12'h0A0, 8'h00, 1'b0, 1'b0, a1c);
    chk("R8", "manual act cycle", a1c - w1, 8);
    idle(8);
    send0(O_WR, 1'b1, 12'd16, 8'hD0, 1'b0, 1'b1, w2);
    chk("R3", "ap bit10", ad0[10], 1);
    send0(O_WR, 1'b0, 12'd0, 8'hD1, 1'b0, 1'b0, c);
    send0(O_WR, 1'b0, 12'd0, 8'hD2, 1'b0, 1'b0, c);
    send0(O_WR, 1'b0, 12'd0, 8'hD3, 1'b1, 1'b0, c);
    send0(O_ACT, 1'b1, 12'h0A0, 8'h00, 1'b0, 1'b0, a2c);
    chk("R8", "ap act cycle", a2c - w2, 8);
    chk("R8", "routes agree", a2c - w2, a1c - w1);
  endtask

  task automatic t_ap_hold();
    int w, r;
    idle(10);
    send0(O_WR, 1'b1, 12'd7, 8'hE0, 1'b1, 1'b1, w);
    send0(O_RD, 1'b0, 12'd2, 8'h00, 1'b0, 1'b0, r);
    chk("R3", "read held to burst end", r - w, 4);
    chk("R3", "read cmd", {ras0, cas0, we0}, C_RD);
  endtask

  task automatic t_full_page();
    int w, c, t0;
    send1(O_WR, 1'b0, 12'd1, 8'hF0, 1'b0, 1'b1, w);
    chk("R9", "ap ignored bit10", ad1[10], 0);
    send1(O_WR, 1'b0, 12'd0, 8'hF1, 1'b0, 1'b0, c);
    send1(O_WR, 1'b0, 12'd0, 8'hF2, 1'b1, 1'b0, c);
    idle(5);
    chk("R9", "run cmd", {ras1, cas1, we1}, C_NOP);
    chk("R9", "run oe", oe1, 1);
    chk("R9", "run dqm", dqm1, 1);
    t0 = cyc;
    send1(O_PRE, 1'b0, 12'd0, 8'h00, 1'b0, 1'b0, c);
    chk("R9", "pre immediate", c - t0, 1);
    chk("R6", "full page pre dqm", dqm1, 1);
    idle(1);
    chk("R9", "burst ended oe", oe1, 0);
  endtask

  task automatic t_two_clk();
    int w, p, a;
    send1(O_WR, 1'b1, 12'd3, 8'h5A, 1'b1, 1'b0, w);
    send1(O_PRE, 1'b1, 12'd0, 8'h00, 1'b0, 1'b0, p);
    chk("R5", "two clock recovery", p - w, 2);
    send1(O_ACT, 1'b1, 12'h033, 8'h00, 1'b0, 1'b0, a);
    chk("R7", "act after pre u1", a - p, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    t_reset();
    t_random();
    t_read_trunc();
    t_pre_trunc();
    t_ap_equiv();
    t_ap_hold();
    t_full_page();
    t_two_clk();
    idle(2);
    report();
  end
endmodule